// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Controller

This block collects interrupt conditions from two serial channels, called A and B, and presents them to a host. Each channel raises three kinds of event: a received character, an empty transmit buffer, and a change on its modem-status inputs (clear-to-send, carrier detect, break). Each event is latched as a pending bit only while its own enable is set. Every pending bit is visible in one six-bit status word. A single active-high request line is raised when a master enable is set and any enabled pending bit is set.

The host writes through a byte-wide port with a three-bit address. Address 0 is the enable register of channel B and address 1 is the enable register of channel A. Address 2 is the command register of channel B and address 3 is the command register of channel A. Address 4 is the shared control register. Addresses 5 to 7 are ignored. The channel logic drives these signals, indexed [0] for B and [1] for A:
- level signals for "receive buffer holds data" and "transmit buffer empty";
- a one-cycle pulse when a character arrives;
- a one-cycle pulse when the host loads a transmit byte;
- the raw clear-to-send, carrier-detect and break levels.

All state is registered, so an input or write seen at a clock edge shows on `pend` and `irq` after that edge.

Top module: `sio_irq_ctrl`

## Requirements
- R1: `pend` places channel B external/status at bit 0, B transmit at bit 1 and B receive at bit 2. Channel A uses bits 3, 4 and 5 for the same three sources.
- R2: In a channel's enable register, bit 0 enables external/status, bit 1 enables transmit, and bits 4:3 set the receive mode. Mode 00 is off, 01 is first character only, 10 is every character, and 11 behaves as off. A source whose enable is clear never sets its pending bit.
- R3: External/status pending sets when any of cts, dcd or brk differs from its value one cycle earlier while that source is enabled. Command code 2, written to bits 5:3 of the command register, clears it. If a change and the clear command arrive in the same cycle, the bit is set.
- R4: Transmit pending sets when transmit-empty rises while transmit is enabled, and stays set while the buffer is empty. A transmit-load pulse clears it, and so does command code 5. A clear arriving in the same cycle as a set wins.
- R5: In every-character mode, each arriving character sets receive pending. The bit clears in any cycle where the buffer is empty and no character arrives.
- R6: In first-character mode, only the first character after arming sets receive pending, and setting it disarms the channel. Command code 6 re-arms it, and the channel is armed after reset. The drain rule of R5 clears the bit.
- R7: `irq` is high exactly when the master enable is set and some pending bit is set whose source is currently enabled. The master enable is bit 3 of the control register.
- R8: Control bits 7:6 set to 01 reset channel B and set to 10 reset channel A. A channel reset clears that channel's enables and pending bits and re-arms it, and leaves the other channel alone. The same write still loads the master enable from bit 3.
- R9: Control bits 7:6 set to 11 is a hardware reset. It clears both channels and the master enable, whatever bit 3 holds.
- R10: After `rst_n` is deasserted, `pend` is zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | 8 | Host write data |
| rx_new | input | 2 | Character-arrived pulse, [1]=A, [0]=B |
| rx_avail | input | 2 | Receive buffer holds data |
| tx_empty | input | 2 | Transmit buffer empty |
| tx_wr | input | 2 | Transmit byte loaded pulse |
| cts | input | 2 | Clear-to-send level |
| dcd | input | 2 | Carrier-detect level |
| brk | input | 2 | Break-detected level |
| pend | output | 6 | Pending-status word |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions check these rules on every cycle:
- the request line stays low while the master enable is clear;
- a transmit-load pulse leaves transmit pending clear on the next cycle;
- a hardware reset empties the status word;
- external pending only rises while its source is enabled;
- receive pending falls once the buffer drains.

Sequence-dependent behaviour needs the bench's scenarios and its cycle model. This covers the single shot of first-character mode and its re-arm by command, set winning over clear on external events, the clear commands on each channel, and a channel reset leaving the other channel untouched.

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rx_new,
  input  logic [1:0] rx_avail,
  input  logic [1:0] tx_empty,
  input  logic [1:0] tx_wr,
  input  logic [1:0] cts,
  input  logic [1:0] dcd,
  input  logic [1:0] brk,
  output logic [5:0] pend,
  output logic       irq
);

  localparam logic [2:0] CODE_CLR_EXT = 3'd2;
  localparam logic [2:0] CODE_CLR_TX  = 3'd5;
  localparam logic [2:0] CODE_REARM   = 3'd6;

  logic            mie;
  logic [1:0]      ext_en, tx_en, ext_p, tx_p, rx_p, rx_arm, tx_empty_q, rx_on;
  logic [1:0][1:0] rx_mode;
  logic [1:0][2:0] ext_q;

  wire       ctl_wr   = wr_en && (wr_addr == 3'd4);
  wire [1:0] rst_code = wr_data[7:6];
  wire [2:0] code     = wr_data[5:3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      mie <= 1'b0;
    else if (ctl_wr) mie <= (rst_code == 2'b11) ? 1'b0 : wr_data[3];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    wire ch_rst = ctl_wr && (rst_code == 2'b11 || rst_code == 2'(c + 1));
    wire cmd    = wr_en && (wr_addr == 3'(c + 2));
    wire en_wr  = wr_en && (wr_addr == 3'(c));
    wire chg    = ext_q[c] != {brk[c], dcd[c], cts[c]};
    wire rx_hit = rx_new[c] && (rx_mode[c] == 2'b10 || (rx_mode[c] == 2'b01 && rx_arm[c]));

    assign rx_on[c] = (rx_mode[c] == 2'b01) || (rx_mode[c] == 2'b10);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ext_en[c]     <= 1'b0;
        tx_en[c]      <= 1'b0;
        rx_mode[c]    <= 2'b00;
        ext_p[c]      <= 1'b0;
        tx_p[c]       <= 1'b0;
        rx_p[c]       <= 1'b0;
        rx_arm[c]     <= 1'b1;
        ext_q[c]      <= 3'b000;
        tx_empty_q[c] <= 1'b0;
      end else begin
        ext_q[c]      <= {brk[c], dcd[c], cts[c]};
        tx_empty_q[c] <= tx_empty[c];
        if (ch_rst) begin
          ext_en[c]  <= 1'b0;
          tx_en[c]   <= 1'b0;
          rx_mode[c] <= 2'b00;
          ext_p[c]   <= 1'b0;
          tx_p[c]    <= 1'b0;
          rx_p[c]    <= 1'b0;
          rx_arm[c]  <= 1'b1;
        end else begin
          if (en_wr) begin
            ext_en[c]  <= wr_data[0];
            tx_en[c]   <= wr_data[1];
            rx_mode[c] <= wr_data[4:3];
          end
          if (ext_en[c] && chg)                   ext_p[c] <= 1'b1;
          else if (cmd && code == CODE_CLR_EXT)   ext_p[c] <= 1'b0;
          if (tx_wr[c] || (cmd && code == CODE_CLR_TX)) tx_p[c] <= 1'b0;
          else if (tx_en[c] && tx_empty[c] && !tx_empty_q[c]) tx_p[c] <= 1'b1;
          if (rx_hit) begin
            rx_p[c] <= 1'b1;
            if (rx_mode[c] == 2'b01) rx_arm[c] <= 1'b0;
          end else if (!rx_avail[c]) rx_p[c] <= 1'b0;
          if (cmd && code == CODE_REARM) rx_arm[c] <= 1'b1;
        end
      end
  end

  assign pend = {rx_p[1], tx_p[1], ext_p[1], rx_p[0], tx_p[0], ext_p[0]};
  assign irq  = mie && |(pend & {rx_on[1], tx_en[1], ext_en[1], rx_on[0], tx_en[0], ext_en[0]});

endmodule

module sio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [1:0] rx_new,
  input logic [1:0] rx_avail,
  input logic [1:0] tx_wr,
  input logic [1:0] ext_en,
  input logic       mie,
  input logic [5:0] pend,
  input logic       irq
);

  assert_irq_needs_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mie |-> !irq);

  assert_tx_load_clears_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr[0] |=> !pend[1]);

  assert_tx_load_clears_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr[1] |=> !pend[4]);

  assert_hw_reset_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd4 && wr_data[7:6] == 2'b11) |=> (pend == 6'd0 && !irq));

  assert_ext_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> $past(ext_en[0]));

  assert_rx_drains_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_avail[0] && !rx_new[0]) |=> !pend[2]);

endmodule

bind sio_irq_ctrl sio_irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rx_new(rx_new), .rx_avail(rx_avail), .tx_wr(tx_wr), .ext_en(ext_en),
  .mie(mie), .pend(pend), .irq(irq)
);

// File: tb/sio_irq_ctrl_tb_top.sv
module sio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rx_new = '0, rx_avail = '0, tx_empty = '0, tx_wr = '0;
  logic [1:0] cts = '0, dcd = '0, brk = '0;
  logic [5:0] pend;
  logic       irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_irq_ctrl dut_i (.*);

  // cycle model built from the requirements
  logic            m_mie;
  logic [1:0]      m_ee, m_te, m_ep, m_tp, m_rp, m_arm, m_txq;
  logic [1:0][1:0] m_mode;
  logic [1:0][2:0] m_extq;

  function automatic logic [5:0] m_pend();
    return {m_rp[1], m_tp[1], m_ep[1], m_rp[0], m_tp[0], m_ep[0]};
  endfunction

  function automatic logic m_irq();
    logic [5:0] en;
    en = {(m_mode[1] == 2'b01 || m_mode[1] == 2'b10), m_te[1], m_ee[1],
          (m_mode[0] == 2'b01 || m_mode[0] == 2'b10), m_te[0], m_ee[0]};
    return m_mie && |(m_pend() & en);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mie = 0; m_ee = 0; m_te = 0; m_ep = 0; m_tp = 0; m_rp = 0;
      m_arm = 2'b11; m_txq = 0; m_mode = '0; m_extq = '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit ctl, rs, cm, ew, ch, hit;
        ctl = wr_en && wr_addr == 3'd4;
        rs  = ctl && (wr_data[7:6] == 2'b11 || int'(wr_data[7:6]) == c + 1);
        cm  = wr_en && int'(wr_addr) == c + 2;
        ew  = wr_en && int'(wr_addr) == c;
        ch  = m_extq[c] != {brk[c], dcd[c], cts[c]};
        hit = rx_new[c] && (m_mode[c] == 2'b10 || (m_mode[c] == 2'b01 && m_arm[c]));
        if (rs) begin
          m_ee[c] = 0; m_te[c] = 0; m_mode[c] = 0;
          m_ep[c] = 0; m_tp[c] = 0; m_rp[c] = 0; m_arm[c] = 1;
        end else begin
          if (ch && m_ee[c]) m_ep[c] = 1;
          else if (cm && wr_data[5:3] == 3'd2) m_ep[c] = 0;
          if (tx_wr[c] || (cm && wr_data[5:3] == 3'd5)) m_tp[c] = 0;
          else if (m_te[c] && tx_empty[c] && !m_txq[c]) m_tp[c] = 1;
          if (hit) begin
            m_rp[c] = 1;
            if (m_mode[c] == 2'b01) m_arm[c] = 0;
          end else if (!rx_avail[c]) m_rp[c] = 0;
          if (cm && wr_data[5:3] == 3'd6) m_arm[c] = 1;
          if (ew) begin
            m_ee[c] = wr_data[0]; m_te[c] = wr_data[1]; m_mode[c] = wr_data[4:3];
          end
        end
        m_extq[c] = {brk[c], dcd[c], cts[c]};
        m_txq[c]  = tx_empty[c];
      end
      if (wr_en && wr_addr == 3'd4) m_mie = (wr_data[7:6] == 2'b11) ? 1'b0 : wr_data[3];
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R1 pend vs model", {2'b0, pend}, {2'b0, m_pend()});
    chk("R7 irq vs model", {7'b0, irq}, {7'b0, m_irq()});
    wr_en = 0; rx_new = 0; tx_wr = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got=hang expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1407));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset pend", {2'b0, pend}, 8'h00);
    chk("R10 reset irq", {7'b0, irq}, 8'h00);

    wr(3'd0, 8'h13);
    wr(3'd4, 8'h08);
    cts[0] = 1; tick();
    chk("R3 ext set", {7'b0, pend[0]}, 8'h01);
    wr(3'd2, 8'h10);
    chk("R3 ext cleared by code 2", {7'b0, pend[0]}, 8'h00);

    tx_empty[0] = 1; tick();
    chk("R4 tx set on empty", {7'b0, pend[1]}, 8'h01);
    tick();
    chk("R4 tx holds while empty", {7'b0, pend[1]}, 8'h01);
    tx_wr[0] = 1; tick();
    chk("R4 tx cleared by load", {7'b0, pend[1]}, 8'h00);
    tx_empty[0] = 0; tick();
    tx_empty[0] = 1; tick();
    wr(3'd2, 8'h28);
    chk("R4 tx cleared by code 5", {7'b0, pend[1]}, 8'h00);

    rx_new[0] = 1; rx_avail[0] = 1; tick();
    chk("R5 rx set", {7'b0, pend[2]}, 8'h01);
    chk("R7 irq with master on", {7'b0, irq}, 8'h01);
    wr(3'd4, 8'h00);
    chk("R7 irq gated by master", {7'b0, irq}, 8'h00);
    rx_avail[0] = 0; tick();
    chk("R5 rx drained", {7'b0, pend[2]}, 8'h00);

    wr(3'd1, 8'h08);
    rx_new[1] = 1; rx_avail[1] = 1; tick();
    chk("R6 first char sets", {7'b0, pend[5]}, 8'h01);
    rx_avail[1] = 0; tick();
    rx_new[1] = 1; rx_avail[1] = 1; tick();
    chk("R6 second char ignored", {7'b0, pend[5]}, 8'h00);
    wr(3'd3, 8'h30);
    rx_new[1] = 1; tick();
    chk("R6 rearmed by code 6", {7'b0, pend[5]}, 8'h01);
    rx_avail[1] = 0; tick();

    wr(3'd1, 8'h0A);
    tx_empty[1] = 1; tick();
    chk("R1 A transmit at bit 4", {2'b0, pend}, 8'h10);

    tx_empty[0] = 0; tick();
    tx_empty[0] = 1; tick();
    wr(3'd4, 8'h48);
    chk("R8 channel B reset keeps A", {2'b0, pend}, 8'h10);
    chk("R8 master loaded on reset write", {7'b0, irq}, 8'h01);
    tx_empty[0] = 0; tick();
    tx_empty[0] = 1; tick();
    chk("R8 B enables cleared", {7'b0, pend[1]}, 8'h00);

    wr(3'd4, 8'hC8);
    chk("R9 hw reset pend", {2'b0, pend}, 8'h00);
    chk("R9 hw reset irq", {7'b0, irq}, 8'h00);
    cts[1] = 1; tick();
    chk("R9 A enables cleared", {2'b0, pend}, 8'h00);

    wr(3'd0, 8'h02);
    cts[0] = 0; tx_empty[0] = 0; tick();
    tx_empty[0] = 1; tick();
    chk("R2 ext off tx on", {2'b0, pend}, 8'h02);

    for (int i = 0; i < 4000; i++) begin
      for (int c = 0; c < 2; c++) begin
        rx_avail[c] = ($urandom % 10) < 7;
        if ($urandom % 6 == 0) begin rx_new[c] = 1; rx_avail[c] = 1; end
        if ($urandom % 8 == 0) tx_empty[c] = ~tx_empty[c];
        tx_wr[c] = ($urandom % 10 == 0);
        if ($urandom % 20 == 0) cts[c] = ~cts[c];
        if ($urandom % 25 == 0) dcd[c] = ~dcd[c];
        if ($urandom % 30 == 0) brk[c] = ~brk[c];
      end
      if ($urandom % 5 == 0) begin
        logic [2:0] a;
        logic [2:0] codes [4];
        codes = '{3'd0, 3'd2, 3'd5, 3'd6};
        a = 3'($urandom % 6);
        wr_en = 1; wr_addr = a;
        if (a == 3'd2 || a == 3'd3) wr_data = {2'b0, codes[$urandom % 4], 3'b0};
        else if (a == 3'd4)
          wr_data = {($urandom % 8 == 0) ? 2'($urandom) : 2'b00, 2'b0, ($urandom % 4 != 0), 3'b0};
        else wr_data = 8'($urandom);
      end
      tick();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule